// File: doc/BRIEF.md
# Edge-to-Pulse Isolation Encoder with Refresh

This block is the sending half of one channel of a pulse-coded isolation link. It synchronises a single logic input into its clock domain and converts every rising transition into a one-cycle set strobe and every falling transition into a one-cycle clear strobe. The strobes drive whatever coupling element carries the channel across the barrier. The far side rebuilds the level from these pulses alone.

A receiver that only sees pulses can lose its state. This happens when a pulse is corrupted, or when either side powers up or down while the input is quiet. To cover that, the encoder watches for inactivity. Once the input has held one level for `IDLE_CYCLES` clocks, it sends a strobe that encodes the present level. It then repeats that strobe every `REFRESH_CYCLES` clocks until the next real transition. The two intervals and the synchroniser depth are parameters given in clock cycles. With the defaults at 100 MHz, the idle threshold is 2 µs and the refresh period is 0.85 µs.

Top module: `edge_pulse_encoder`

## Requirements
- R1: A rising transition of `dataIn` produces exactly one `setStrobe` pulse, one clock wide. It appears on the (SYNC_STAGES+1)-th rising clock edge after the change, which is the 3rd edge with the defaults.
- R2: A falling transition of `dataIn` produces exactly one `clrStrobe` pulse, one clock wide, with the same latency as R1.
- R3: `setStrobe` and `clrStrobe` are never high together, and neither stays high for two consecutive cycles.
- R4: While `dataIn` holds steady, no strobe is issued other than the refresh strobes of R5 and R6. Over any window, the number of strobes equals the number of transitions plus the number of refreshes due.
- R5: With no further transition, the first refresh strobe appears IDLE_CYCLES+1 clock edges after the transition strobe. It is `setStrobe` when the input is high and `clrStrobe` when it is low.
- R6: After the first refresh, a further refresh strobe of the same polarity follows every REFRESH_CYCLES clock edges for as long as the input stays steady.
- R7: A transition during the refresh phase stops the refresh train and issues its own transition strobe. Idle timing then restarts, so the next refresh comes IDLE_CYCLES+1 edges after that strobe.
- R8: After reset is released, no strobe appears during the first IDLE_CYCLES clock edges, even when `dataIn` was already high. On edge IDLE_CYCLES+1, one refresh strobe matching the input level appears.
- R9: While `rstN` is low, both strobe outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encoder clock |
| rstN | input | 1 | Asynchronous reset, active low |
| dataIn | input | 1 | Logic level to be carried across the link, asynchronous to `clk` |
| setStrobe | output | 1 | One-cycle pulse meaning "far side goes high" |
| clrStrobe | output | 1 | One-cycle pulse meaning "far side goes low" |

## Verification
The embedded properties check four things on every cycle. The two strobes never overlap, and neither lasts longer than one cycle. A strobe always agrees with the synchronised level seen the cycle before. Refresh requests are never back to back, and the idle counter never passes its threshold. What only the scenarios can show is the exact cycle placement. That covers the transition latency, the first refresh landing exactly one idle interval after the last transition, the spacing of later refreshes, the restart when a transition cuts into a refresh train, and the quiet start-up window after reset with the input already high.

// File: rtl/epe_pkg.sv
package epe_pkg;

  // Datapath -> control: what the synchronised input did this cycle.
  typedef struct packed {
    logic rise;
    logic fall;
    logic level;
  } edge_evt_t;

  // Control -> datapath: refresh strobe requests.
  typedef struct packed {
    logic sendSet;
    logic sendClr;
  } ctl_cmd_t;

endpackage

// File: rtl/epe_sync.sv
module epe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[0] <= 1'b0;
        else       chain[0] <= din;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[i] <= 1'b0;
        else       chain[i] <= chain[i-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/epe_datapath.sv
module epe_datapath
  import epe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      syncLvl,
  input  ctl_cmd_t  cmd,
  output edge_evt_t evt,
  output logic      setStrobe,
  output logic      clrStrobe
);

  localparam int ARM_W = SYNC_STAGES + 1;

  // Fills with ones after reset; edges are ignored until the synchroniser
  // and the previous-level flop hold real samples.
  logic [ARM_W-1:0] armSr;
  logic             prevLvl;
  logic             armed;

  assign armed = armSr[ARM_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armSr     <= '0;
      prevLvl   <= 1'b0;
      setStrobe <= 1'b0;
      clrStrobe <= 1'b0;
    end else begin
      armSr     <= {armSr[ARM_W-2:0], 1'b1};
      prevLvl   <= syncLvl;
      setStrobe <= evt.rise | cmd.sendSet;
      clrStrobe <= evt.fall | cmd.sendClr;
    end
  end

  always_comb begin
    evt.level = syncLvl;
    evt.rise  = armed &  syncLvl & ~prevLvl;
    evt.fall  = armed & ~syncLvl &  prevLvl;
  end

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(setStrobe && clrStrobe));
  // R3
  set_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    setStrobe |=> !setStrobe);
  // R3
  clr_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrStrobe |=> !clrStrobe);
  // R1
  set_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    setStrobe |-> $past(syncLvl));
  // R2
  clr_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrStrobe |-> !$past(syncLvl));

endmodule

// File: rtl/epe_control.sv
module epe_control
  import epe_pkg::*;
#(
  parameter int IDLE_CYCLES    = 200,
  parameter int REFRESH_CYCLES = 85
) (
  input  logic      clk,
  input  logic      rstN,
  input  edge_evt_t evt,
  output ctl_cmd_t  cmd
);

  localparam int IW = $clog2(IDLE_CYCLES + 1);
  localparam int RW = (REFRESH_CYCLES > 2) ? $clog2(REFRESH_CYCLES) : 1;
  localparam logic [IW-1:0] IDLE_LIM = IW'(IDLE_CYCLES);
  localparam logic [RW-1:0] REF_LAST = RW'(REFRESH_CYCLES - 1);

  logic [IW-1:0] idleCnt;
  logic [RW-1:0] refCnt;
  logic          anyEdge;
  logic          idleDone;
  logic          fire;

  assign anyEdge  = evt.rise | evt.fall;
  assign idleDone = (idleCnt == IDLE_LIM);
  assign fire     = idleDone & (refCnt == '0) & ~anyEdge;

  // Idle timer: cleared by every real transition, saturates at the threshold.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         idleCnt <= '0;
    else if (anyEdge)  idleCnt <= '0;
    else if (!idleDone) idleCnt <= idleCnt + 1'b1;
  end

  // Refresh period timer: runs only once the idle threshold is reached.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   refCnt <= '0;
    else if (!idleDone || anyEdge) refCnt <= '0;
    else if (refCnt == REF_LAST) refCnt <= '0;
    else                         refCnt <= refCnt + 1'b1;
  end

  always_comb begin
    cmd.sendSet = fire &  evt.level;
    cmd.sendClr = fire & ~evt.level;
  end

  // R6
  fire_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.sendSet || cmd.sendClr) |=> !(cmd.sendSet || cmd.sendClr));
  // R4
  idle_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    idleCnt <= IDLE_LIM);

endmodule

// File: rtl/edge_pulse_encoder.sv
module edge_pulse_encoder
  import epe_pkg::*;
#(
  parameter int IDLE_CYCLES    = 200,
  parameter int REFRESH_CYCLES = 85,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic dataIn,
  output logic setStrobe,
  output logic clrStrobe
);

  logic      syncLvl;
  edge_evt_t evt;
  ctl_cmd_t  cmd;

  epe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (dataIn),
    .dout (syncLvl)
  );

  epe_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .syncLvl   (syncLvl),
    .cmd       (cmd),
    .evt       (evt),
    .setStrobe (setStrobe),
    .clrStrobe (clrStrobe)
  );

  epe_control #(
    .IDLE_CYCLES    (IDLE_CYCLES),
    .REFRESH_CYCLES (REFRESH_CYCLES)
  ) u_ctl (
    .clk  (clk),
    .rstN (rstN),
    .evt  (evt),
    .cmd  (cmd)
  );

endmodule

// File: tb/edge_pulse_encoder_tb.sv
module edge_pulse_encoder_tb;

  localparam int IDLE = 200;
  localparam int REF  = 85;
  localparam int LAT  = 3;
  localparam int NVEC = 11;

  typedef struct packed {
    logic        lvl;
    logic [15:0] hold;
    logic [15:0] expSet;
    logic [15:0] expClr;
  } vec_t;

  // Each row: drive level, hold for N samples, strobe counts seen in that window.
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 16'd10,  16'd1, 16'd0},
    '{1'b0, 16'd250, 16'd0, 16'd2},
    '{1'b1, 16'd400, 16'd4, 16'd0},
    '{1'b0, 16'd3,   16'd0, 16'd1},
    '{1'b1, 16'd3,   16'd1, 16'd0},
    '{1'b0, 16'd150, 16'd0, 16'd1},
    '{1'b1, 16'd1,   16'd0, 16'd0},
    '{1'b0, 16'd5,   16'd1, 16'd1},
    '{1'b1, 16'd100, 16'd1, 16'd0},
    '{1'b1, 16'd150, 16'd1, 16'd0},
    '{1'b0, 16'd300, 16'd0, 16'd3}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dataIn = 1'b0;
  logic setStrobe, clrStrobe;

  int runCnt = 0;
  int failCnt = 0;
  int bothErr = 0;
  int wideErr = 0;
  logic lastSet = 1'b0;
  logic lastClr = 1'b0;

  always #10 clk = ~clk;

  edge_pulse_encoder #(.IDLE_CYCLES(IDLE), .REFRESH_CYCLES(REF)) u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .dataIn    (dataIn),
    .setStrobe (setStrobe),
    .clrStrobe (clrStrobe)
  );

  // R3 monitor: overlap and width, every cycle out of reset.
  always @(negedge clk) begin
    if (rstN) begin
      if (setStrobe && clrStrobe) bothErr++;
      if ((setStrobe && lastSet) || (clrStrobe && lastClr)) wideErr++;
    end
    lastSet = setStrobe;
    lastClr = clrStrobe;
  end

  task automatic check(input string tag, input int got, input int exp);
    runCnt++;
    if (got !== exp) begin
      failCnt++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic sample(output logic s, output logic c);
    @(negedge clk);
    #1;
    s = setStrobe;
    c = clrStrobe;
  endtask

  task automatic window(input int n, output int ns, output int nc);
    logic s, c;
    ns = 0;
    nc = 0;
    for (int k = 0; k < n; k++) begin
      sample(s, c);
      ns += int'(s);
      nc += int'(c);
    end
  endtask

  // Samples until a strobe; idx continues counting from start.
  task automatic nextStrobe(input int start, output int idx, output logic s);
    logic c;
    idx = start;
    s = 1'b0;
    for (int k = 0; k < 1000; k++) begin
      sample(s, c);
      idx++;
      if (s || c) break;
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    runCnt++;
    failCnt++;
    $display("FAIL watchdog expired (all requirements): got hang expected completion");
    summary();
    $finish;
  end

  initial begin
    logic s, c;
    int ns, nc, idx;

    // R9: reset state
    for (int k = 0; k < 3; k++) begin
      sample(s, c);
      check("R9 outputs low in reset", int'(s) + int'(c), 0);
    end
    rstN = 1'b1;
    window(5, ns, nc);

    // Table walk (R4 counts; R5/R6 refreshes inside long holds)
    for (int i = 0; i < NVEC; i++) begin
      dataIn = VECS[i].lvl;
      window(int'(VECS[i].hold), ns, nc);
      check($sformatf("R4 row %0d set count", i), ns, int'(VECS[i].expSet));
      check($sformatf("R4 row %0d clr count", i), nc, int'(VECS[i].expClr));
    end

    // R1: rising latency and width
    dataIn = 1'b1;
    sample(s, c); check("R1 no strobe at edge 1", int'(s) + int'(c), 0);
    sample(s, c); check("R1 no strobe at edge 2", int'(s) + int'(c), 0);
    sample(s, c); check("R1 set at edge 3", int'(s), 1);
    check("R1 no clr at edge 3", int'(c), 0);
    sample(s, c); check("R1 one cycle wide", int'(s) + int'(c), 0);

    // R5: first refresh position and polarity
    nextStrobe(LAT + 1, idx, s);
    check("R5 first refresh edge", idx, LAT + IDLE + 1);
    check("R5 refresh is set while high", int'(s), 1);
    // R6: period
    nextStrobe(idx, idx, s);
    check("R6 second refresh edge", idx, LAT + IDLE + 1 + REF);
    check("R6 refresh polarity", int'(s), 1);

    // R7: transition inside the refresh train
    window(40, ns, nc);
    dataIn = 1'b0;
    sample(s, c); check("R2 no strobe at edge 1", int'(s) + int'(c), 0);
    sample(s, c); check("R2 no strobe at edge 2", int'(s) + int'(c), 0);
    sample(s, c); check("R2 clr at edge 3", int'(c), 1);
    check("R2 no set at edge 3", int'(s), 0);
    nextStrobe(LAT, idx, s);
    check("R7 restarted refresh edge", idx, LAT + IDLE + 1);
    check("R7 refresh is clr while low", int'(s), 0);

    // R8: reset with input already high
    dataIn = 1'b1;
    rstN = 1'b0;
    for (int k = 0; k < 4; k++) begin
      sample(s, c);
      check("R9 outputs low in reset (input high)", int'(s) + int'(c), 0);
    end
    rstN = 1'b1;
    window(IDLE, ns, nc);
    check("R8 quiet after reset", ns + nc, 0);
    sample(s, c);
    check("R8 first refresh set", int'(s), 1);
    check("R8 first refresh not clr", int'(c), 0);

    // R3: monitor results
    check("R3 overlapping strobes", bothErr, 0);
    check("R3 strobe wider than one cycle", wideErr, 0);

    summary();
    $finish;
  end

endmodule